// File: doc/BRIEF.md
# Motor Starter Sequencer

This block steps a three-phase motor starter through five modes: ready, starting, running, stopping and fault. A single state register holds the mode as a sparse decimal code, and the register changes only when an explicit transition condition holds. The contactor command is a pure function of that register, so the coil can never hold sequence memory of its own.

Operator buttons (start, stop, fault reset) and field signals (overload trip, permissive, run proof, stopped proof) enter through two-flop synchronisers. Start and fault reset act on their rising edge only. A held button therefore cannot restart the motor, and it cannot clear a fault a second time. Two internal counters bound the wait for run proof and the wait for the motor to stop. A start that never proves ends in a latched fault, and only an operator reset with the trip cleared leaves that fault.

Top module: `motor_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to code 0 and `contactor_on` is low.
- R2: `state_code` only ever holds 0 (ready), 10 (starting), 20 (running), 30 (stopping) or 99 (fault). `contactor_on` is high exactly in codes 10 and 20.
- R3: From code 0, the block goes to 10 only on a rising edge of `start_btn` while `ovl_trip` is low and `permit_ok` is high. A start button held high after a return to code 0 does not start the motor again.
- R4: In code 10, `run_proof` high moves the block to code 20.
- R5: In code 10 with `run_proof` low, the block spends START_TIMEOUT+1 clock cycles in code 10 and then enters code 99.
- R6: In code 20, `ovl_trip` high or `permit_ok` low moves the block to 99. Otherwise `stop_btn` high moves it to 30. A trip wins over a stop given in the same cycle.
- R7: In code 30, `stop_proof` high moves the block to 0. Without that proof, the block spends STOP_TIMEOUT+1 cycles in code 30 and then returns to 0.
- R8: Code 99 is left only for code 0, and only on a rising edge of `reset_btn` while `ovl_trip` is low. A reset edge seen while the trip is still active is consumed, and the block does not leave fault on its own afterwards.
- R9: A change on any input changes `state_code` at the third rising clock edge after the change, not earlier.
- R10: In code 10, a trip moves the block to 99 ahead of everything else, and a stop moves it to 30 ahead of run proof. In code 30, a trip moves the block to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start push-button, acts on rising edge |
| stop_btn | input | 1 | Stop command, level |
| reset_btn | input | 1 | Fault reset push-button, acts on rising edge |
| ovl_trip | input | 1 | Overload trip, high when tripped |
| permit_ok | input | 1 | Permissive chain healthy |
| run_proof | input | 1 | Auxiliary contact proof of running |
| stop_proof | input | 1 | Motor confirmed stopped |
| contactor_on | output | 1 | Motor contactor command |
| state_code | output | 8 | Current mode code for diagnostics |

## Verification
The bench sweeps every combination of start, trip and permissive in ready mode, and every combination of stop, trip and permissive loss in running mode. A design with a wrong priority would stop instead of tripping, or start against a tripped overload. It counts the exact number of cycles spent starting and stopping when proof never arrives, which exposes an off-by-one timer or a timer that does not clear on entry. It holds start through a full cycle back to ready and presses reset while the trip is still active. A level-sensitive design would restart by itself there, or leave fault as soon as the trip cleared. It also samples one cycle before the expected change, so a missing synchroniser stage shows up as an early transition.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [CODE_W-1:0] {
        MS_READY    = 8'd0,
        MS_STARTING = 8'd10,
        MS_RUNNING  = 8'd20,
        MS_STOPPING = 8'd30,
        MS_FAULT    = 8'd99
    } mstate_e;

    // Conditioned (synchronised) inputs seen by the transition logic
    typedef struct packed {
        logic start_rise;
        logic reset_rise;
        logic stop_req;
        logic trip;
        logic permit;
        logic run_fb;
        logic stopped_fb;
    } mseq_in_t;

    // Bit positions inside the raw input vector handed to the synchroniser
    localparam int IN_START  = 0;
    localparam int IN_STOP   = 1;
    localparam int IN_RESET  = 2;
    localparam int IN_TRIP   = 3;
    localparam int IN_PERMIT = 4;
    localparam int IN_RUN    = 5;
    localparam int IN_STOPPED = 6;
    localparam int IN_COUNT  = 7;

    function automatic logic motor_energized(logic [CODE_W-1:0] code);
        return (code == MS_STARTING) || (code == MS_RUNNING);
    endfunction

endpackage

// File: rtl/mseq_sync.sv
module mseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mseq_rise.sv
module mseq_rise #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/mseq_timer.sv
module mseq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == LIM_V);

    // Cleared whenever the owning mode is absent, so every entry starts at zero
    always_ff @(posedge clk) begin
        if (rst || !run)   cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import motor_seq_pkg::*;
#(
    parameter bit USE_STOP_TIMER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  mseq_in_t          cin,
    input  logic              start_exp,
    input  logic              stop_exp,
    output logic [CODE_W-1:0] state
);
    logic [CODE_W-1:0] state_q;
    logic [CODE_W-1:0] state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            MS_READY: begin
                if (cin.start_rise && !cin.trip && cin.permit) state_d = MS_STARTING;
            end
            MS_STARTING: begin
                if (cin.trip)          state_d = MS_FAULT;
                else if (cin.stop_req) state_d = MS_STOPPING;
                else if (cin.run_fb)   state_d = MS_RUNNING;
                else if (start_exp)    state_d = MS_FAULT;
            end
            MS_RUNNING: begin
                if (cin.trip || !cin.permit) state_d = MS_FAULT;
                else if (cin.stop_req)       state_d = MS_STOPPING;
            end
            MS_STOPPING: begin
                if (cin.trip) state_d = MS_FAULT;
                else if (cin.stopped_fb || (USE_STOP_TIMER && stop_exp)) state_d = MS_READY;
            end
            MS_FAULT: begin
                if (cin.reset_rise && !cin.trip) state_d = MS_READY;
            end
            default: state_d = MS_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MS_READY;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/motor_seq_ctrl.sv
module motor_seq_ctrl
    import motor_seq_pkg::*;
#(
    parameter int START_TIMEOUT  = 250000,
    parameter int STOP_TIMEOUT   = 100000,
    parameter bit USE_STOP_TIMER = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_btn,
    input  logic       stop_btn,
    input  logic       reset_btn,
    input  logic       ovl_trip,
    input  logic       permit_ok,
    input  logic       run_proof,
    input  logic       stop_proof,
    output logic       contactor_on,
    output logic [7:0] state_code
);
    logic [IN_COUNT-1:0] raw_in;
    logic [IN_COUNT-1:0] sync_in;
    logic [1:0]          btn_rise;
    logic                start_exp;
    logic                stop_exp;
    logic [CODE_W-1:0]   cur_state;
    mseq_in_t            cin;

    always_comb begin
        raw_in             = '0;
        raw_in[IN_START]   = start_btn;
        raw_in[IN_STOP]    = stop_btn;
        raw_in[IN_RESET]   = reset_btn;
        raw_in[IN_TRIP]    = ovl_trip;
        raw_in[IN_PERMIT]  = permit_ok;
        raw_in[IN_RUN]     = run_proof;
        raw_in[IN_STOPPED] = stop_proof;
    end

    mseq_sync #(.WIDTH(IN_COUNT), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    mseq_rise #(.WIDTH(2)) u_rise (
        .clk   (clk),
        .rst   (rst),
        .level ({sync_in[IN_RESET], sync_in[IN_START]}),
        .rise  (btn_rise)
    );

    always_comb begin
        cin.start_rise = btn_rise[0];
        cin.reset_rise = btn_rise[1];
        cin.stop_req   = sync_in[IN_STOP];
        cin.trip       = sync_in[IN_TRIP];
        cin.permit     = sync_in[IN_PERMIT];
        cin.run_fb     = sync_in[IN_RUN];
        cin.stopped_fb = sync_in[IN_STOPPED];
    end

    mseq_timer #(.LIMIT(START_TIMEOUT)) u_start_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (cur_state == MS_STARTING),
        .expired (start_exp)
    );

    mseq_timer #(.LIMIT(STOP_TIMEOUT)) u_stop_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (cur_state == MS_STOPPING),
        .expired (stop_exp)
    );

    mseq_core #(.USE_STOP_TIMER(USE_STOP_TIMER)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cin       (cin),
        .start_exp (start_exp),
        .stop_exp  (stop_exp),
        .state     (cur_state)
    );

    assign state_code   = cur_state;
    assign contactor_on = motor_energized(cur_state);
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] state_code,
    input logic       contactor_on
);
    // R2: only the five legal codes appear
    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        (state_code == 8'd0 || state_code == 8'd10 || state_code == 8'd20 ||
         state_code == 8'd30 || state_code == 8'd99));

    // R2: the coil is dropped in fault
    a_r2_fault_coil_off: assert property (@(posedge clk) disable iff (rst)
        (state_code == 8'd99) |-> !contactor_on);

    // R3: ready only ever advances to starting
    a_r3_ready_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == 8'd0 && state_code != 8'd0) |-> state_code == 8'd10);

    // R4: starting leaves only to running, stopping or fault
    a_r4_starting_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == 8'd10 && state_code != 8'd10) |->
        (state_code == 8'd20 || state_code == 8'd30 || state_code == 8'd99));

    // R6: running leaves only to stopping or fault
    a_r6_running_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == 8'd20 && state_code != 8'd20) |->
        (state_code == 8'd30 || state_code == 8'd99));

    // R7: stopping leaves only to ready or fault
    a_r7_stopping_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == 8'd30 && state_code != 8'd30) |->
        (state_code == 8'd0 || state_code == 8'd99));

    // R8: fault leaves only to ready
    a_r8_fault_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == 8'd99 && state_code != 8'd99) |-> state_code == 8'd0);
endmodule

bind motor_seq_ctrl mseq_checker u_mseq_chk (
    .clk          (clk),
    .rst          (rst),
    .state_code   (state_code),
    .contactor_on (contactor_on)
);

// File: tb/motor_seq_ctrl_bench.sv
module motor_seq_ctrl_bench;
    localparam int START_TO = 5;
    localparam int STOP_TO  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_btn = 1'b0, stop_btn = 1'b0, reset_btn = 1'b0;
    logic       ovl_trip = 1'b0, permit_ok = 1'b1, run_proof = 1'b0, stop_proof = 1'b0;
    logic       contactor_on;
    logic [7:0] state_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    motor_seq_ctrl #(
        .START_TIMEOUT  (START_TO),
        .STOP_TIMEOUT   (STOP_TO),
        .USE_STOP_TIMER (1'b1)
    ) u_motor_seq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_btn    (start_btn),
        .stop_btn     (stop_btn),
        .reset_btn    (reset_btn),
        .ovl_trip     (ovl_trip),
        .permit_ok    (permit_ok),
        .run_proof    (run_proof),
        .stop_proof   (stop_proof),
        .contactor_on (contactor_on),
        .state_code   (state_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input logic [7:0] exp, input string tag);
        logic exp_on;
        exp_on = (exp == 8'd10) || (exp == 8'd20);
        checks++;
        if (state_code !== exp || contactor_on !== exp_on) begin
            errors++;
            $display("FAIL %s: state=%0d motor=%0b expected state=%0d motor=%0b",
                     tag, state_code, contactor_on, exp, exp_on);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_btn = 0; stop_btn = 0; reset_btn = 0;
        ovl_trip = 0; permit_ok = 1; run_proof = 0; stop_proof = 0;
    endtask

    task automatic hard_reset();
        idle_inputs();
        rst = 1;
        step(3);
        rst = 0;
        step(3);
    endtask

    task automatic go_running(input string tag);
        start_btn = 1;
        step(3);
        check_state(8'd10, tag);
        start_btn = 0;
        run_proof = 1;
        step(3);
        check_state(8'd20, tag);
        run_proof = 0;
    endtask

    task automatic dwell(input logic [7:0] code, output int n);
        n = 0;
        while (state_code == code && n < 100) begin
            n++;
            step(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        step(3);
        // R1: state during and right after reset
        check_state(8'd0, "R1 reset");
        rst = 0;
        step(3);
        check_state(8'd0, "R1 after release");

        // R9: latency of three edges
        start_btn = 1;
        step(2);
        check_state(8'd0, "R9 no early change");
        step(1);
        check_state(8'd10, "R9 change at third edge");
        start_btn = 0;
        step(2);

        // R3: sweep start/trip/permit in ready (bit0 start, bit1 trip, bit2 permit)
        for (int m = 0; m < 8; m++) begin
            hard_reset();
            start_btn = m[0];
            ovl_trip  = m[1];
            permit_ok = m[2];
            step(3);
            check_state((m == 5) ? 8'd10 : 8'd0, $sformatf("R3 ready sweep m=%0d", m));
        end

        // R4 and R2: normal run
        hard_reset();
        go_running("R4 proof to running");

        // R6: sweep stop/trip/permit-loss in running (bit0 stop, bit1 trip, bit2 permit lost)
        for (int m = 0; m < 8; m++) begin
            logic [7:0] exp;
            hard_reset();
            go_running("R6 setup");
            stop_btn  = m[0];
            ovl_trip  = m[1];
            permit_ok = !m[2];
            step(3);
            exp = (m[1] || m[2]) ? 8'd99 : (m[0] ? 8'd30 : 8'd20);
            check_state(exp, $sformatf("R6 run sweep m=%0d", m));
        end

        // R5: start proof timeout
        hard_reset();
        start_btn = 1;
        step(3);
        start_btn = 0;
        dwell(8'd10, n);
        check_int(n, START_TO + 1, "R5 cycles in starting");
        check_state(8'd99, "R5 timeout fault");

        // R8: reset while trip active is consumed, no self-exit
        ovl_trip = 1;
        reset_btn = 1;
        step(4);
        check_state(8'd99, "R8 reset with trip active");
        ovl_trip = 0;
        step(5);
        check_state(8'd99, "R8 held reset after trip clears");
        reset_btn = 0;
        step(3);
        check_state(8'd99, "R8 reset release");
        reset_btn = 1;
        step(3);
        check_state(8'd0, "R8 reset edge exits fault");
        reset_btn = 0;

        // R7: stop timer exit
        hard_reset();
        go_running("R7 setup");
        stop_btn = 1;
        step(3);
        stop_btn = 0;
        dwell(8'd30, n);
        check_int(n, STOP_TO + 1, "R7 cycles in stopping");
        check_state(8'd0, "R7 timer return to ready");

        // R7: stopped proof exit
        go_running("R7 setup proof");
        stop_btn = 1;
        step(3);
        check_state(8'd30, "R7 stopping");
        stop_btn = 0;
        stop_proof = 1;
        step(3);
        check_state(8'd0, "R7 proof return to ready");
        stop_proof = 0;

        // R3: held start does not restart after returning to ready
        hard_reset();
        start_btn = 1;
        step(3);
        run_proof = 1;
        step(3);
        check_state(8'd20, "R3 held start running");
        run_proof = 0;
        stop_btn = 1;
        step(3);
        stop_btn = 0;
        stop_proof = 1;
        step(3);
        check_state(8'd0, "R3 back to ready");
        step(6);
        check_state(8'd0, "R3 held start no re-entry");
        start_btn = 0;
        stop_proof = 0;

        // R10: stop over proof in starting
        hard_reset();
        start_btn = 1;
        step(3);
        start_btn = 0;
        stop_btn = 1;
        run_proof = 1;
        step(3);
        check_state(8'd30, "R10 stop over proof");
        stop_btn = 0;
        run_proof = 0;

        // R10: trip in stopping
        ovl_trip = 1;
        step(3);
        check_state(8'd99, "R10 trip in stopping");

        // R10: trip over stop and proof in starting
        hard_reset();
        start_btn = 1;
        step(3);
        start_btn = 0;
        ovl_trip = 1;
        stop_btn = 1;
        run_proof = 1;
        step(3);
        check_state(8'd99, "R10 trip in starting");
        idle_inputs();
        step(6);
        check_state(8'd99, "R8 no auto restart");

        // R1: reset from fault
        rst = 1;
        step(1);
        check_state(8'd0, "R1 reset from fault");
        rst = 0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule